// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface

This block is the host-facing front end of a display controller. A microprocessor talks to it over one of four bus styles, picked by two static mode pins: a parallel bus with a read/write level and an enable pulse, a parallel bus with separate active-low read and write strobes, a serial bus with a separate data/command pin, or a serial bus that carries the data/command bit inside each frame. Every accepted write comes out on the system-clock side as a byte, a flag that tells display data from a command, and a single-cycle valid strobe.

All host pins are brought into the system clock through two-flop synchronisers. Edges are detected on the synchronised copies. In the parallel modes the host may also read. The block then drives the data bus from a read-data input and raises an output enable. It also gives a one-cycle read-request pulse, so the source of the read data can advance. The serial modes reuse data-bus bit 6 as the serial clock and bit 7 as the serial data, and they never drive the bus.

Top module: `hbi_host_if`

## Requirements
- R1: The mode pins {mode_a, mode_b} select the bus: 2'b11 parallel enable-qualified, 2'b10 parallel strobed, 2'b01 four-wire serial, 2'b00 three-wire serial.
- R2: While cs_n is high, no write is emitted and db_oe stays low.
- R3: In the parallel and four-wire modes, wr_is_data copies rs: 1 for display data, 0 for a command.
- R4: In mode 2'b11, a falling edge of en_rd with rw_wr low and cs_n low emits the byte on db_in.
- R5: In mode 2'b11, with cs_n low, rw_wr high and en_rd high, db_oe is high and db_out equals rd_data, and no write is emitted.
- R6: In mode 2'b10, a rising edge of rw_wr (active-low write strobe) with cs_n low emits the byte on db_in.
- R7: In mode 2'b10, with cs_n low and en_rd (active-low read strobe) low, db_oe is high and db_out equals rd_data.
- R8: In the serial modes, db_oe never rises. In four-wire mode, db_in[7] is shifted MSB first on rising edges of db_in[6], and after 8 bits the byte is emitted with the flag taken from rs.
- R9: In three-wire mode a frame is 9 bits: the first bit is the flag (1 = data) and the next 8 are the byte MSB first. The rs pin is ignored.
- R10: Raising cs_n in the middle of a serial frame discards the partial frame, and the next frame starts from bit 0.
- R11: A synchronous low on rst_n clears wr_valid, db_oe, rd_req and the serial bit count.
- R12: Each accepted write gives wr_valid high for exactly one clock.
- R13: Each parallel read gives one single-cycle rd_req pulse at its start: the rising edge of en_rd in mode 2'b11, or the falling edge of en_rd in mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_a | input | 1 | Static bus-style select, high bit |
| mode_b | input | 1 | Static bus-style select, low bit |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 1 data, 0 command |
| rw_wr | input | 1 | Read/write level (mode 11) or write strobe, active low (mode 10) |
| en_rd | input | 1 | Enable pulse (mode 11) or read strobe, active low (mode 10) |
| db_in | input | 8 | Data bus input; bit 7 serial data, bit 6 serial clock |
| db_out | output | 8 | Data bus output value for reads |
| db_oe | output | 1 | Data bus output enable |
| rd_data | input | 8 | Byte supplied for host reads |
| rd_req | output | 1 | One-cycle pulse when a host read starts |
| wr_valid | output | 1 | One-cycle strobe for each received byte |
| wr_byte | output | 8 | Received byte |
| wr_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
The bench drives strobes while chip select is high and expects silence. A design that gated on the unsynchronised pin, or ignored the select, would emit stray bytes or drive the bus. It sends three-wire frames with rs set opposite to the frame's first bit, so a design that took the flag from the pin shows the wrong flag. It aborts serial frames part way, both by chip select and by reset, and then sends a full frame. A counter that kept its old count would misalign that frame and emit a wrong byte. It holds read levels in the serial modes, which catches a design that drove the bus there.

// File: rtl/hbi_pkg.sv
// Package: shared types for the host bus interface.
// Assumes: mode pins are static while chip select is active.
package hbi_pkg;
    typedef enum logic [1:0] {
        BUS_SER3  = 2'b00,
        BUS_SER4  = 2'b01,
        BUS_STRB  = 2'b10,
        BUS_ENQ   = 2'b11
    } bus_mode_e;
endpackage

// File: rtl/hbi_sync.sv
// Module: hbi_sync
// Two-flop synchroniser for a vector of asynchronous host pins.
// Assumes: bits are sampled independently; multi-bit values are only
// used when the host holds them stable around the qualifying strobe.
module hbi_sync #(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Purpose: two register stages toward the system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/hbi_par.sv
// Module: hbi_par
// Parallel bus engine for the enable-qualified and strobed styles.
// Captures writes on the strobe edge and flags reads.
// Assumes: inputs are already synchronised; data held stable across the strobe.
module hbi_par #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              enq_style,
    input  logic              cs_s,
    input  logic              rs_s,
    input  logic              rw_s,
    input  logic              en_s,
    input  logic [DATA_W-1:0] db_s,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_dc,
    output logic              rd_req,
    output logic              rd_active
);
    logic rw_q, en_q;
    logic wr_edge, rd_edge;

    // Purpose: pick the write and read start events for the active style.
    always_comb begin
        if (enq_style) begin
            wr_edge = en_q && !en_s && !rw_s;
            rd_edge = !en_q && en_s && rw_s;
        end else begin
            wr_edge = !rw_q && rw_s;
            rd_edge = en_q && !en_s;
        end
    end

    // Purpose: read window level that drives the bus enable.
    assign rd_active = enable && !cs_s && (enq_style ? (rw_s && en_s) : !en_s);

    // Purpose: previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q <= 1'b1;
            en_q <= 1'b0;
        end else begin
            rw_q <= rw_s;
            en_q <= en_s;
        end
    end

    // Purpose: register write strobe, byte, flag and read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_byte  <= '0;
            wr_dc    <= 1'b0;
            rd_req   <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_req   <= 1'b0;
            if (enable && !cs_s && wr_edge) begin
                wr_valid <= 1'b1;
                wr_byte  <= db_s;
                wr_dc    <= rs_s;
            end
            if (enable && !cs_s && rd_edge) begin
                rd_req <= 1'b1;
            end
        end
    end

    assert_par_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    assert_rdreq_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
endmodule

// File: rtl/hbi_ser.sv
// Module: hbi_ser
// Serial shifter for the four-wire and three-wire styles.
// Shifts MSB first on rising serial clock; the three-wire frame leads with a flag bit.
// Assumes: inputs synchronised; serial clock slow against the system clock.
module hbi_ser #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              three_wire,
    input  logic              cs_s,
    input  logic              rs_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_dc
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST_4W = CW'(DATA_W - 1);
    localparam logic [CW-1:0] LAST_3W = CW'(DATA_W);

    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              dc_q;
    logic              sclk_q;
    logic              sclk_rise;
    logic [CW-1:0]     last_bit;
    logic [DATA_W-1:0] next_sh;

    assign sclk_rise = sclk_s && !sclk_q;
    assign last_bit  = three_wire ? LAST_3W : LAST_4W;
    assign next_sh   = {sh_q[DATA_W-2:0], sdi_s};

    // Purpose: previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Purpose: bit counter, shift register and byte emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            dc_q     <= 1'b0;
            wr_valid <= 1'b0;
            wr_byte  <= '0;
            wr_dc    <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            if (!enable || cs_s) begin
                cnt_q <= '0;
            end else if (sclk_rise) begin
                if (three_wire && cnt_q == '0) begin
                    dc_q  <= sdi_s;
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    sh_q <= next_sh;
                    if (cnt_q == last_bit) begin
                        wr_valid <= 1'b1;
                        wr_byte  <= next_sh;
                        wr_dc    <= three_wire ? dc_q : rs_s;
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_3W);
    assert_abort_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s || !enable) |=> cnt_q == '0);
    assert_ser_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
endmodule

// File: rtl/hbi_host_if.sv
// Module: hbi_host_if (top)
// Host bus front end: synchronises pins, decodes the bus style and
// merges parallel and serial writes into one byte stream.
// Assumes: mode pins change only while cs_n is high.
module hbi_host_if #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_a,
    input  logic              mode_b,
    input  logic              cs_n,
    input  logic              rs,
    input  logic              rw_wr,
    input  logic              en_rd,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_is_data
);
    import hbi_pkg::*;

    localparam int SW = DATA_W + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b0, {DATA_W{1'b0}}};

    bus_mode_e         mode;
    logic              par_en, ser_en, enq_style, three_wire;
    logic [SW-1:0]     pins_s;
    logic              cs_s, rs_s, rw_s, en_s;
    logic [DATA_W-1:0] db_s;
    logic              p_valid, s_valid, p_dc, s_dc, p_rd;
    logic [DATA_W-1:0] p_byte, s_byte;

    // Purpose: decode the static bus style.
    always_comb begin
        mode       = bus_mode_e'({mode_a, mode_b});
        par_en     = (mode == BUS_ENQ) || (mode == BUS_STRB);
        ser_en     = !par_en;
        enq_style  = (mode == BUS_ENQ);
        three_wire = (mode == BUS_SER3);
    end

    hbi_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cs_n, rs, rw_wr, en_rd, db_in}),
        .q_sync  (pins_s)
    );

    assign {cs_s, rs_s, rw_s, en_s, db_s} = pins_s;

    hbi_par #(.DATA_W(DATA_W)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (par_en),
        .enq_style (enq_style),
        .cs_s      (cs_s),
        .rs_s      (rs_s),
        .rw_s      (rw_s),
        .en_s      (en_s),
        .db_s      (db_s),
        .wr_valid  (p_valid),
        .wr_byte   (p_byte),
        .wr_dc     (p_dc),
        .rd_req    (rd_req),
        .rd_active (p_rd)
    );

    hbi_ser #(.DATA_W(DATA_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ser_en),
        .three_wire (three_wire),
        .cs_s       (cs_s),
        .rs_s       (rs_s),
        .sclk_s     (db_s[DATA_W-2]),
        .sdi_s      (db_s[DATA_W-1]),
        .wr_valid   (s_valid),
        .wr_byte    (s_byte),
        .wr_dc      (s_dc)
    );

    // Purpose: merge the two write sources and drive the read bus.
    always_comb begin
        wr_valid   = p_valid || s_valid;
        wr_byte    = p_valid ? p_byte : s_byte;
        wr_is_data = p_valid ? p_dc : s_dc;
        db_oe      = rst_n && p_rd;
        db_out     = rd_data;
    end

    assert_serial_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_a) |-> !db_oe);
    assert_cs_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !wr_valid);
    assert_one_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_valid && s_valid));
endmodule

// File: tb/hbi_host_if_tb.sv
module hbi_host_if_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed { logic [7:0] b; logic dc; } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_a = 1'b1, mode_b = 1'b1;
    logic       cs_n = 1'b1, rs = 1'b0, rw_wr = 1'b1, en_rd = 1'b0;
    logic [7:0] db_in = '0, rd_data = '0;
    logic [7:0] db_out, wr_byte;
    logic       db_oe, rd_req, wr_valid, wr_is_data;

    int  tests = 0, fails = 0, exp_rd = 0, rd_seen = 0;
    bit  mon_on = 1'b0, done = 1'b0;
    bit  prev_v = 1'b0, prev_r = 1'b0;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbi_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .cs_n(cs_n), .rs(rs), .rw_wr(rw_wr), .en_rd(en_rd), .db_in(db_in),
        .db_out(db_out), .db_oe(db_oe), .rd_data(rd_data), .rd_req(rd_req),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_is_data(wr_is_data)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b, logic dc);
        item_t it;
        it.b = b; it.dc = dc;
        exp_q.push_back(it);
    endtask

    // Monitor: pops expected writes and checks strobe widths.
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected write", {23'd0, wr_byte, wr_is_data}, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(wr_byte == it.b, "R4", "write byte", wr_byte, it.b);
                    check(wr_is_data == it.dc, "R3", "data flag", wr_is_data, it.dc);
                end
            end
            if (prev_v && wr_valid) check(1'b0, "R12", "wr_valid width", 2, 1);
            if (prev_r && rd_req)   check(1'b0, "R13", "rd_req width", 2, 1);
            if (rd_req) rd_seen++;
            prev_v = wr_valid;
            prev_r = rd_req;
        end
    end

    task automatic enq_write(logic [7:0] b, logic dc, bit sel);
        if (sel) push(b, dc);
        rs = dc; rw_wr = 1'b0; db_in = b; cs_n = !sel; tick(3);
        en_rd = 1'b1; tick(3);
        en_rd = 1'b0; tick(3);
        cs_n = 1'b1; rw_wr = 1'b1; tick(3);
    endtask

    task automatic enq_read(logic [7:0] v);
        exp_rd++;
        rd_data = v; rw_wr = 1'b1; cs_n = 1'b0; tick(3);
        en_rd = 1'b1; tick(4);
        check(db_oe == 1'b1, "R5", "enable-style read oe", db_oe, 1);
        check(db_out == v, "R5", "enable-style read data", db_out, v);
        en_rd = 1'b0; tick(3);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic strb_write(logic [7:0] b, logic dc);
        push(b, dc);
        rs = dc; db_in = b; cs_n = 1'b0; tick(3);
        rw_wr = 1'b0; tick(3);
        rw_wr = 1'b1; tick(3);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic strb_read(logic [7:0] v);
        exp_rd++;
        rd_data = v; cs_n = 1'b0; tick(3);
        en_rd = 1'b0; tick(4);
        check(db_oe == 1'b1, "R7", "strobed read oe", db_oe, 1);
        check(db_out == v, "R7", "strobed read data", db_out, v);
        en_rd = 1'b1; tick(4);
        check(db_oe == 1'b0, "R7", "oe after read", db_oe, 0);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic ser_bits(logic [8:0] bits, int n);
        for (int i = n - 1; i >= 0; i--) begin
            db_in[7] = bits[i]; db_in[6] = 1'b0; tick(3);
            db_in[6] = 1'b1; tick(3);
        end
        db_in[6] = 1'b0; tick(3);
    endtask

    task automatic ser_frame(logic [8:0] bits, int n, logic rs_v);
        rs = rs_v; cs_n = 1'b0; tick(3);
        ser_bits(bits, n);
        cs_n = 1'b1; tick(3);
    endtask

    initial begin
        tick(4);
        check(wr_valid == 1'b0, "R11", "wr_valid in reset", wr_valid, 0);
        check(db_oe == 1'b0, "R11", "db_oe in reset", db_oe, 0);
        rst_n = 1'b1; tick(4);
        mon_on = 1'b1;

        // R1 mode 2'b11: enable-qualified parallel
        mode_a = 1'b1; mode_b = 1'b1; tick(3);
        enq_write(8'hA5, 1'b1, 1'b1);   // R4, R3 data
        enq_write(8'h3C, 1'b0, 1'b1);   // R4, R3 command
        enq_write(8'hFF, 1'b1, 1'b0);   // R2: cs_n high, ignored
        enq_read(8'h5A);                 // R5
        // R2: read levels with cs_n high
        rw_wr = 1'b1; en_rd = 1'b1; tick(5);
        check(db_oe == 1'b0, "R2", "oe with cs_n high", db_oe, 0);
        en_rd = 1'b0; tick(3);

        // R1 mode 2'b10: strobed parallel
        en_rd = 1'b1; rw_wr = 1'b1; mode_a = 1'b1; mode_b = 1'b0; tick(4);
        strb_write(8'h81, 1'b1);         // R6
        strb_write(8'h7E, 1'b0);         // R6, R3
        strb_read(8'hC3);                // R7

        // R1 mode 2'b01: four-wire serial, bus held at read levels
        mode_a = 1'b0; mode_b = 1'b1; rw_wr = 1'b1; en_rd = 1'b1; tick(4);
        push(8'hB4, 1'b1); ser_frame(9'h0B4, 8, 1'b1);   // R8
        push(8'h12, 1'b0); ser_frame(9'h012, 8, 1'b0);   // R8, R3
        cs_n = 1'b0; tick(5);
        check(db_oe == 1'b0, "R8", "serial never drives", db_oe, 0);
        cs_n = 1'b1; tick(3);
        ser_frame(9'h1FF, 3, 1'b1);                      // R10 aborted
        push(8'h69, 1'b1); ser_frame(9'h069, 8, 1'b1);   // R10 clean restart

        // R11: reset in mid-frame with cs_n held low
        rs = 1'b0; cs_n = 1'b0; tick(3);
        ser_bits(9'h1FF, 4);
        rst_n = 1'b0; tick(3);
        check(wr_valid == 1'b0 && db_oe == 1'b0, "R11", "outputs in mid reset", {wr_valid, db_oe}, 0);
        rst_n = 1'b1; tick(4);
        push(8'hC0, 1'b0); ser_bits(9'h0C0, 8);
        cs_n = 1'b1; tick(3);

        // R1 mode 2'b00: three-wire serial, rs opposite to frame flag (R9)
        mode_a = 1'b0; mode_b = 1'b0; tick(4);
        push(8'h96, 1'b1); ser_frame({1'b1, 8'h96}, 9, 1'b0);   // R9
        push(8'h0F, 1'b0); ser_frame({1'b0, 8'h0F}, 9, 1'b1);   // R9
        ser_frame(9'h1AA, 5, 1'b0);                             // R10 aborted
        push(8'h55, 1'b1); ser_frame({1'b1, 8'h55}, 9, 1'b0);   // R10

        tick(10);
        check(exp_q.size() == 0, "R12", "writes left unseen", exp_q.size(), 0);
        check(rd_seen == exp_rd, "R13", "rd_req count", rd_seen, exp_rd);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule